// File: doc/BRIEF.md
# Out-of-Order Multi-Issue Dispatch Window

This block holds a short, ordered queue of decoded operations taken from the head of a serial instruction stream. Slot 0 always holds the oldest operation. Every cycle the block looks at all slots at once. It picks each operation that has no conflict with any older operation still waiting or executing, and that can get a free functional unit of its class. Several operations may go out in one cycle, and a younger one may overtake a stalled older one.

Each operation names its unit class, two source registers, a destination register and whether it reads or writes the condition codes. It also carries a fence bit for branches, calls and traps, and an opaque tag that comes back on the issue outputs. Units have fixed latencies. When an operation's latency has elapsed it leaves the window. The survivors close up toward slot 0, and new operations enter in lane order behind them. A fetch stall tells the front end when the window cannot take a full group.

Top module: `dispatch_window`

## Requirements
- R1: After reset the window is empty, `issue_mask` is all zero and `fetch_stall` is low.
- R2: An operation accepted at a clock edge can issue at the next edge if nothing blocks it. Independent operations accepted together issue in the same cycle. Each operation issues exactly once.
- R3: An operation that reads a register written by an older live operation issues exactly L edges after that writer issued. L is the writer's class latency: memory 1, integer 1, FP ALU 2, FP multiply 3, FP divide 6, FP square root 8. Class codes are memory 0, integer 1, FP ALU 2, FP multiply 3, FP divide 4, FP square root 5.
- R4: An operation that writes a register which an older live operation reads or writes waits until that older operation has issued and its latency has elapsed.
- R5: A destination of register 0 never creates a dependence, whether the other operation reads or writes register 0.
- R6: The condition codes are a dependence resource. A condition-code writer orders against every older or younger condition-code reader or writer. Two condition-code readers do not order against each other.
- R7: Per class, no more operations execute at once than there are units (defaults: 2 integer, 1 of every other class). A unit is held for the class latency. When units are short, older ready operations win.
- R8: A younger independent operation issues ahead of an older blocked one.
- R9: No operation younger than a fence operation issues before the fence has issued and its latency has elapsed.
- R10: `fetch_stall` is high while occupancy exceeds DEPTH minus ACCEPT. Operations presented during a stall are dropped and never issue.
- R11: Operations whose latency has elapsed leave the window. The rest close up toward slot 0, and new operations enter behind them, so a window that has drained accepts and issues again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | ACCEPT | Per-lane new-operation valid; lane 0 is older |
| in_class | input | 3*ACCEPT | Per-lane unit class code |
| in_src_a | input | 5*ACCEPT | Per-lane first source register |
| in_src_b | input | 5*ACCEPT | Per-lane second source register |
| in_dst | input | 5*ACCEPT | Per-lane destination register (0 = none) |
| in_cc_rd | input | ACCEPT | Per-lane reads condition codes |
| in_cc_wr | input | ACCEPT | Per-lane writes condition codes |
| in_fence | input | ACCEPT | Per-lane branch/call/trap fence |
| in_tag | input | 4*ACCEPT | Per-lane opaque tag |
| fetch_stall | output | 1 | Window cannot take a full group this cycle |
| issue_mask | output | DEPTH | Registered: slot issued at the last edge |
| issue_class | output | 3*DEPTH | Registered class of each issued slot |
| issue_tag | output | 4*DEPTH | Registered tag of each issued slot |

## Verification
An operation presented before edge N enters the window at N. If free, it issues at N+1 and appears on the registered issue outputs just after that edge. A dependent operation's issue edge is its producer's issue edge plus the producer's class latency. The bench counts clock edges and logs, for every tag, the edge count read on the falling edge after it appeared. Each check then compares that logged edge number with the acceptance edge plus the number of edges derived from the latencies above. `fetch_stall` depends only on occupancy, so it is sampled on the falling edge after the load that filled the window.

// File: rtl/dwin_pkg.sv
`timescale 1ns/1ps
package dwin_pkg;
  localparam int REG_W   = 5;
  localparam int TAG_W   = 4;
  localparam int LAT_W   = 4;
  localparam int N_CLASS = 6;

  typedef enum logic [2:0] {
    CL_MEM   = 3'd0,
    CL_INT   = 3'd1,
    CL_FALU  = 3'd2,
    CL_FMUL  = 3'd3,
    CL_FDIV  = 3'd4,
    CL_FSQRT = 3'd5
  } op_class_e;

  // dependence-relevant fields of one operation
  typedef struct packed {
    logic [REG_W-1:0] src_a;
    logic [REG_W-1:0] src_b;
    logic [REG_W-1:0] dst;
    logic             cc_rd;
    logic             cc_wr;
    logic             fence;
  } dw_deps_t;

  typedef struct packed {
    op_class_e        cls;
    dw_deps_t         deps;
    logic [TAG_W-1:0] tag;
  } dw_op_t;

  typedef struct packed {
    logic             used;
    logic             sent;
    logic [LAT_W-1:0] left;
    dw_op_t           op;
  } dw_slot_t;

  // true when the two operations may not overlap in time
  function automatic logic deps_clash(input dw_deps_t older, input dw_deps_t younger);
    logic ow, yw;
    ow = (older.dst != '0);
    yw = (younger.dst != '0);
    deps_clash = (ow && (older.dst == younger.src_a || older.dst == younger.src_b))
              || (yw && (younger.dst == older.src_a || younger.dst == older.src_b))
              || (ow && yw && (older.dst == younger.dst))
              || (older.cc_wr && (younger.cc_rd || younger.cc_wr))
              || (younger.cc_wr && older.cc_rd);
  endfunction
endpackage

// File: rtl/dwin_hazard.sv
`timescale 1ns/1ps
module dwin_hazard
  import dwin_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  dw_deps_t           deps  [DEPTH],
  input  logic [DEPTH-1:0]   live,
  output logic [DEPTH-1:0]   blocked
);
  // slot j is blocked by any older live slot that clashes or is a fence
  always_comb begin
    blocked = '0;
    for (int j = 1; j < DEPTH; j++) begin
      for (int i = 0; i < j; i++) begin
        if (live[i] && (deps[i].fence || deps_clash(deps[i], deps[j])))
          blocked[j] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dwin_select.sv
`timescale 1ns/1ps
module dwin_select
  import dwin_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int U_MEM   = 1,
  parameter int U_INT   = 2,
  parameter int U_FALU  = 1,
  parameter int U_FMUL  = 1,
  parameter int U_FDIV  = 1,
  parameter int U_FSQRT = 1,
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int SUM_W  = CNT_W + 2
) (
  input  logic [DEPTH-1:0]   cand,
  input  op_class_e          cls   [DEPTH],
  input  logic [CNT_W-1:0]   busy  [N_CLASS],
  output logic [DEPTH-1:0]   grant
);
  function automatic int unit_cnt(input logic [2:0] c);
    case (c)
      3'd0:    unit_cnt = U_MEM;
      3'd1:    unit_cnt = U_INT;
      3'd2:    unit_cnt = U_FALU;
      3'd3:    unit_cnt = U_FMUL;
      3'd4:    unit_cnt = U_FDIV;
      3'd5:    unit_cnt = U_FSQRT;
      default: unit_cnt = 0;
    endcase
  endfunction

  logic [SUM_W-1:0] taken [N_CLASS];
  logic [2:0]       cidx;

  // walk from oldest to youngest so older candidates claim units first
  always_comb begin
    grant = '0;
    cidx  = '0;
    for (int c = 0; c < N_CLASS; c++) taken[c] = '0;
    for (int j = 0; j < DEPTH; j++) begin
      cidx = cls[j];
      if (cand[j] && (cidx < 3'(N_CLASS))) begin
        if ((SUM_W'(busy[cidx]) + taken[cidx]) < SUM_W'(unit_cnt(cidx))) begin
          grant[j]    = 1'b1;
          taken[cidx] = taken[cidx] + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dwin_compact.sv
`timescale 1ns/1ps
module dwin_compact
  import dwin_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ACCEPT = 2,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  dw_slot_t            cur      [DEPTH],
  input  logic [DEPTH-1:0]    keep,
  input  logic                accept,
  input  logic [ACCEPT-1:0]   in_valid,
  input  dw_op_t              in_op    [ACCEPT],
  output dw_slot_t            nxt      [DEPTH]
);
  logic [DEPTH-1:0] nxt_used;

  always_comb begin : pack
    logic [CNT_W-1:0] fill;
    for (int k = 0; k < DEPTH; k++) nxt[k] = '0;
    fill = '0;
    // survivors keep their relative order, moving toward slot 0
    for (int i = 0; i < DEPTH; i++) begin
      if (keep[i]) begin
        if (fill < CNT_W'(DEPTH)) nxt[fill[IDX_W-1:0]] = cur[i];
        fill = fill + 1'b1;
      end
    end
    // new operations enter behind the survivors in lane order
    if (accept) begin
      for (int w = 0; w < ACCEPT; w++) begin
        if (in_valid[w]) begin
          if (fill < CNT_W'(DEPTH))
            nxt[fill[IDX_W-1:0]] = '{used: 1'b1, sent: 1'b0, left: '0, op: in_op[w]};
          fill = fill + 1'b1;
        end
      end
    end
  end

  always_comb begin
    for (int k = 0; k < DEPTH; k++) nxt_used[k] = nxt[k].used;
  end

  AST_COMPACT_COUNT: assert property (@(posedge clk) disable iff (rst)
    $countones(nxt_used) == ($countones(keep) + (accept ? $countones(in_valid) : 0))); // R11
endmodule

// File: rtl/dispatch_window.sv
`timescale 1ns/1ps
module dispatch_window
  import dwin_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int ACCEPT    = 2,
  parameter int U_MEM     = 1,
  parameter int U_INT     = 2,
  parameter int U_FALU    = 1,
  parameter int U_FMUL    = 1,
  parameter int U_FDIV    = 1,
  parameter int U_FSQRT   = 1,
  parameter int LAT_FALU  = 2,
  parameter int LAT_FMUL  = 3,
  parameter int LAT_FDIV  = 6,
  parameter int LAT_FSQRT = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [ACCEPT-1:0]         in_valid,
  input  logic [ACCEPT*3-1:0]       in_class,
  input  logic [ACCEPT*REG_W-1:0]   in_src_a,
  input  logic [ACCEPT*REG_W-1:0]   in_src_b,
  input  logic [ACCEPT*REG_W-1:0]   in_dst,
  input  logic [ACCEPT-1:0]         in_cc_rd,
  input  logic [ACCEPT-1:0]         in_cc_wr,
  input  logic [ACCEPT-1:0]         in_fence,
  input  logic [ACCEPT*TAG_W-1:0]   in_tag,
  output logic                      fetch_stall,
  output logic [DEPTH-1:0]          issue_mask,
  output logic [DEPTH*3-1:0]        issue_class,
  output logic [DEPTH*TAG_W-1:0]    issue_tag
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  dw_slot_t         slot_q   [DEPTH];
  dw_slot_t         slot_upd [DEPTH];
  dw_slot_t         slot_nxt [DEPTH];
  dw_deps_t         slot_dep [DEPTH];
  op_class_e        slot_cls [DEPTH];
  dw_op_t           new_op   [ACCEPT];
  logic [CNT_W-1:0] busy     [N_CLASS];
  logic [DEPTH-1:0] used_vec, live, retire, keep, blocked, cand, grant;
  logic [CNT_W-1:0] occ;
  logic             accept;

  function automatic logic [LAT_W-1:0] class_lat(input op_class_e c);
    case (c)
      CL_FALU:  class_lat = LAT_W'(LAT_FALU);
      CL_FMUL:  class_lat = LAT_W'(LAT_FMUL);
      CL_FDIV:  class_lat = LAT_W'(LAT_FDIV);
      CL_FSQRT: class_lat = LAT_W'(LAT_FSQRT);
      default:  class_lat = LAT_W'(1);
    endcase
  endfunction

  function automatic int class_units(input int c);
    case (c)
      0:       class_units = U_MEM;
      1:       class_units = U_INT;
      2:       class_units = U_FALU;
      3:       class_units = U_FMUL;
      4:       class_units = U_FDIV;
      default: class_units = U_FSQRT;
    endcase
  endfunction

  // unpack the flat input lanes
  always_comb begin
    for (int w = 0; w < ACCEPT; w++) begin
      new_op[w].cls         = op_class_e'(in_class[w*3 +: 3]);
      new_op[w].deps.src_a  = in_src_a[w*REG_W +: REG_W];
      new_op[w].deps.src_b  = in_src_b[w*REG_W +: REG_W];
      new_op[w].deps.dst    = in_dst[w*REG_W +: REG_W];
      new_op[w].deps.cc_rd  = in_cc_rd[w];
      new_op[w].deps.cc_wr  = in_cc_wr[w];
      new_op[w].deps.fence  = in_fence[w];
      new_op[w].tag         = in_tag[w*TAG_W +: TAG_W];
    end
  end

  // per-slot status: an entry in its final latency cycle no longer blocks
  always_comb begin
    for (int j = 0; j < DEPTH; j++) begin
      used_vec[j] = slot_q[j].used;
      retire[j]   = slot_q[j].used && slot_q[j].sent && (slot_q[j].left == LAT_W'(1));
      live[j]     = slot_q[j].used && !retire[j];
      keep[j]     = live[j];
      cand[j]     = slot_q[j].used && !slot_q[j].sent && !blocked[j];
      slot_dep[j] = slot_q[j].op.deps;
      slot_cls[j] = slot_q[j].op.cls;
    end
  end

  // units still held beyond this cycle, per class
  always_comb begin
    for (int c = 0; c < N_CLASS; c++) busy[c] = '0;
    for (int j = 0; j < DEPTH; j++) begin
      if (slot_q[j].used && slot_q[j].sent && (slot_q[j].left > LAT_W'(1))
          && (slot_q[j].op.cls <= CL_FSQRT))
        busy[slot_q[j].op.cls] = busy[slot_q[j].op.cls] + 1'b1;
    end
  end

  assign occ         = CNT_W'($countones(used_vec));
  assign fetch_stall = (occ > CNT_W'(DEPTH - ACCEPT));
  assign accept      = !fetch_stall;

  dwin_hazard #(.DEPTH(DEPTH)) u_hazard (
    .deps    (slot_dep),
    .live    (live),
    .blocked (blocked)
  );

  dwin_select #(
    .DEPTH(DEPTH), .U_MEM(U_MEM), .U_INT(U_INT), .U_FALU(U_FALU),
    .U_FMUL(U_FMUL), .U_FDIV(U_FDIV), .U_FSQRT(U_FSQRT)
  ) u_select (
    .cand  (cand),
    .cls   (slot_cls),
    .busy  (busy),
    .grant (grant)
  );

  // mark issued entries and count down executing ones
  always_comb begin
    for (int j = 0; j < DEPTH; j++) begin
      slot_upd[j] = slot_q[j];
      if (grant[j]) begin
        slot_upd[j].sent = 1'b1;
        slot_upd[j].left = class_lat(slot_q[j].op.cls);
      end else if (slot_q[j].used && slot_q[j].sent && (slot_q[j].left > LAT_W'(1))) begin
        slot_upd[j].left = slot_q[j].left - 1'b1;
      end
    end
  end

  dwin_compact #(.DEPTH(DEPTH), .ACCEPT(ACCEPT)) u_compact (
    .clk      (clk),
    .rst      (rst),
    .cur      (slot_upd),
    .keep     (keep),
    .accept   (accept),
    .in_valid (in_valid),
    .in_op    (new_op),
    .nxt      (slot_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int j = 0; j < DEPTH; j++) slot_q[j] <= '0;
      issue_mask  <= '0;
      issue_class <= '0;
      issue_tag   <= '0;
    end else begin
      for (int j = 0; j < DEPTH; j++) begin
        slot_q[j]                   <= slot_nxt[j];
        issue_class[j*3 +: 3]       <= grant[j] ? slot_q[j].op.cls : 3'd0;
        issue_tag[j*TAG_W +: TAG_W] <= grant[j] ? slot_q[j].op.tag : '0;
      end
      issue_mask <= grant;
    end
  end

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    fetch_stall |=> (occ <= $past(occ))); // R10

  generate
    for (genvar c = 0; c < N_CLASS; c++) begin : g_unit_chk
      AST_UNIT_BOUND: assert property (@(posedge clk) disable iff (rst)
        busy[c] <= CNT_W'(class_units(c))); // R7
    end
    for (genvar j = 0; j < DEPTH; j++) begin : g_slot_chk
      AST_ISSUE_ONCE: assert property (@(posedge clk) disable iff (rst)
        grant[j] |-> (slot_q[j].used && !slot_q[j].sent)); // R2
      AST_HAZARD_CLEAR: assert property (@(posedge clk) disable iff (rst)
        grant[j] |-> !blocked[j]); // R3
    end
  endgenerate
endmodule

// File: tb/tb_dispatch_window.sv
`timescale 1ns/1ps
module tb_dispatch_window;
  localparam int DEPTH = 8;
  localparam int ACC   = 2;
  localparam logic [2:0] K_MEM = 3'd0, K_INT = 3'd1, K_FALU = 3'd2,
                         K_FMUL = 3'd3, K_FDIV = 3'd4, K_FSQRT = 3'd5;

  typedef struct packed {
    logic [2:0] cls;
    logic [4:0] sa, sb, d;
    logic       cr, cw, fn;
    logic [3:0] tag;
  } bop_t;

  logic clk = 1'b0, rst = 1'b1;
  logic [ACC-1:0]       in_valid = '0;
  logic [ACC*3-1:0]     in_class = '0;
  logic [ACC*5-1:0]     in_src_a = '0, in_src_b = '0, in_dst = '0;
  logic [ACC-1:0]       in_cc_rd = '0, in_cc_wr = '0, in_fence = '0;
  logic [ACC*4-1:0]     in_tag = '0;
  logic                 fetch_stall;
  logic [DEPTH-1:0]     issue_mask;
  logic [DEPTH*3-1:0]   issue_class;
  logic [DEPTH*4-1:0]   issue_tag;

  int total = 0, bad = 0, cyc = 0;
  int icyc [16];
  int icnt [16];

  always #10 clk = ~clk;

  dispatch_window dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_class(in_class),
    .in_src_a(in_src_a), .in_src_b(in_src_b), .in_dst(in_dst),
    .in_cc_rd(in_cc_rd), .in_cc_wr(in_cc_wr), .in_fence(in_fence),
    .in_tag(in_tag), .fetch_stall(fetch_stall), .issue_mask(issue_mask),
    .issue_class(issue_class), .issue_tag(issue_tag)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst) begin
      for (int s = 0; s < DEPTH; s++) begin
        if (issue_mask[s]) begin
          icyc[issue_tag[s*4 +: 4]] = cyc;
          icnt[issue_tag[s*4 +: 4]] = icnt[issue_tag[s*4 +: 4]] + 1;
        end
      end
    end
  end

  function automatic bop_t mk(logic [2:0] c, logic [4:0] a, logic [4:0] b, logic [4:0] d,
                              logic cr, logic cw, logic fn, logic [3:0] t);
    mk = '{cls: c, sa: a, sb: b, d: d, cr: cr, cw: cw, fn: fn, tag: t};
  endfunction

  task automatic check(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clear_log();
    for (int t = 0; t < 16; t++) begin icyc[t] = -1; icnt[t] = 0; end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // present up to two operations; acc is the edge that takes them in
  task automatic push(bop_t x, logic vx, bop_t y, logic vy, output int acc);
    @(negedge clk);
    in_valid = {vy, vx};
    in_class = {y.cls, x.cls};
    in_src_a = {y.sa, x.sa};
    in_src_b = {y.sb, x.sb};
    in_dst   = {y.d, x.d};
    in_cc_rd = {y.cr, x.cr};
    in_cc_wr = {y.cw, x.cw};
    in_fence = {y.fn, x.fn};
    in_tag   = {y.tag, x.tag};
    acc = cyc + 1;
    @(posedge clk);
    #1 in_valid = '0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1", "stall after reset", int'(fetch_stall), 0);
    check("R1", "issue mask after reset", int'(issue_mask), 0);
  endtask

  task automatic t_multi();
    int a;
    clear_log();
    push(mk(K_INT, 5'd2, 5'd3, 5'd1, 0, 0, 0, 4'd0), 1,
         mk(K_INT, 5'd5, 5'd6, 5'd4, 0, 0, 0, 4'd1), 1, a);
    idle(12);
    check("R2", "tag0 issue edge", icyc[0], a + 1);
    check("R2", "tag1 same edge", icyc[1], a + 1);
    check("R2", "tag0 issued once", icnt[0], 1);
  endtask

  task automatic t_raw_ooo();
    int a, b;
    clear_log();
    push(mk(K_FMUL, 5'd9, 5'd10, 5'd8, 0, 0, 0, 4'd2), 1,
         mk(K_INT, 5'd8, 5'd12, 5'd11, 0, 0, 0, 4'd3), 1, a);
    push(mk(K_INT, 5'd14, 5'd15, 5'd13, 0, 0, 0, 4'd4), 1, mk(0,0,0,0,0,0,0,0), 0, b);
    idle(12);
    check("R3", "multiply issue", icyc[2], a + 1);
    check("R3", "reader waits multiply latency", icyc[3], a + 4);
    check("R8", "younger independent issue", icyc[4], b + 1);
    check("R8", "younger before older", int'(icyc[4] < icyc[3]), 1);
  endtask

  task automatic t_war_waw();
    int a;
    clear_log();
    push(mk(K_FMUL, 5'd3, 5'd17, 5'd16, 0, 0, 0, 4'd5), 1,
         mk(K_INT, 5'd18, 5'd19, 5'd3, 0, 0, 0, 4'd6), 1, a);
    idle(12);
    check("R4", "write after read waits", icyc[6], a + 4);
    clear_log();
    push(mk(K_FDIV, 5'd21, 5'd22, 5'd20, 0, 0, 0, 4'd7), 1,
         mk(K_FALU, 5'd23, 5'd24, 5'd20, 0, 0, 0, 4'd8), 1, a);
    idle(14);
    check("R4", "write after write waits", icyc[8], a + 7);
  endtask

  task automatic t_reg0();
    int a;
    clear_log();
    push(mk(K_FDIV, 5'd1, 5'd2, 5'd0, 0, 0, 0, 4'd9), 1,
         mk(K_INT, 5'd0, 5'd3, 5'd0, 0, 0, 0, 4'd10), 1, a);
    idle(12);
    check("R5", "r0 writer issue", icyc[9], a + 1);
    check("R5", "r0 reader/writer not held", icyc[10], a + 1);
  endtask

  task automatic t_cc();
    int a;
    clear_log();
    push(mk(K_INT, 5'd1, 5'd2, 5'd3, 0, 1, 0, 4'd11), 1,
         mk(K_INT, 5'd4, 5'd5, 5'd6, 1, 0, 0, 4'd12), 1, a);
    idle(12);
    check("R6", "cc writer issue", icyc[11], a + 1);
    check("R6", "cc reader waits", icyc[12], a + 2);
    clear_log();
    push(mk(K_FALU, 5'd1, 5'd2, 5'd3, 1, 0, 0, 4'd13), 1,
         mk(K_INT, 5'd4, 5'd5, 5'd6, 1, 0, 0, 4'd14), 1, a);
    idle(12);
    check("R6", "cc reader A", icyc[13], a + 1);
    check("R6", "cc readers together", icyc[14], a + 1);
  endtask

  task automatic t_units();
    int a;
    clear_log();
    push(mk(K_MEM, 5'd1, 5'd2, 5'd3, 0, 0, 0, 4'd0), 1,
         mk(K_MEM, 5'd4, 5'd5, 5'd6, 0, 0, 0, 4'd1), 1, a);
    idle(12);
    check("R7", "older memory op first", icyc[0], a + 1);
    check("R7", "younger memory op next", icyc[1], a + 2);
    clear_log();
    push(mk(K_FDIV, 5'd1, 5'd2, 5'd3, 0, 0, 0, 4'd2), 1,
         mk(K_FDIV, 5'd4, 5'd5, 5'd6, 0, 0, 0, 4'd3), 1, a);
    idle(16);
    check("R7", "first divide", icyc[2], a + 1);
    check("R7", "second divide after unit frees", icyc[3], a + 7);
  endtask

  task automatic t_fence();
    int a, b;
    clear_log();
    push(mk(K_FMUL, 5'd1, 5'd2, 5'd3, 0, 1, 0, 4'd4), 1,
         mk(K_INT, 5'd0, 5'd0, 5'd0, 1, 0, 1, 4'd5), 1, a);
    push(mk(K_INT, 5'd7, 5'd8, 5'd9, 0, 0, 0, 4'd6), 1, mk(0,0,0,0,0,0,0,0), 0, b);
    idle(14);
    check("R9", "fence waits on cc", icyc[5], a + 4);
    check("R9", "younger held behind fence", icyc[6], a + 5);
    check("R9", "fence before younger", int'(icyc[5] < icyc[6]), 1);
  endtask

  task automatic t_stall_refill();
    int a, b;
    clear_log();
    push(mk(K_FSQRT, 5'd2, 5'd3, 5'd1, 0, 0, 0, 4'd0), 1,
         mk(K_FSQRT, 5'd2, 5'd3, 5'd1, 0, 0, 0, 4'd1), 1, a);
    push(mk(K_FSQRT, 5'd2, 5'd3, 5'd1, 0, 0, 0, 4'd2), 1,
         mk(K_FSQRT, 5'd2, 5'd3, 5'd1, 0, 0, 0, 4'd3), 1, b);
    push(mk(K_FSQRT, 5'd2, 5'd3, 5'd1, 0, 0, 0, 4'd4), 1,
         mk(K_FSQRT, 5'd2, 5'd3, 5'd1, 0, 0, 0, 4'd5), 1, b);
    @(negedge clk);
    check("R10", "no stall at six entries", int'(fetch_stall), 0);
    push(mk(K_FSQRT, 5'd2, 5'd3, 5'd1, 0, 0, 0, 4'd6), 1,
         mk(K_FSQRT, 5'd2, 5'd3, 5'd1, 0, 0, 0, 4'd7), 1, b);
    @(negedge clk);
    check("R10", "stall when full", int'(fetch_stall), 1);
    // offer an independent operation while stalled; it must be dropped
    for (int k = 0; k < 5; k++) begin
      in_valid = 2'b01;
      in_class = {3'd0, K_INT};
      in_src_a = '0; in_src_b = '0; in_dst = {5'd0, 5'd30};
      in_cc_rd = '0; in_cc_wr = '0; in_fence = '0;
      in_tag   = {4'd0, 4'd15};
      @(negedge clk);
    end
    in_valid = '0;
    idle(70);
    check("R10", "stalled input never issued", icnt[15], 0);
    check("R10", "stall released after drain", int'(fetch_stall), 0);
    check("R4", "write chain spacing", icyc[1] - icyc[0], 8);
    check("R7", "last of chain", icyc[7], a + 57);
    clear_log();
    push(mk(K_INT, 5'd4, 5'd5, 5'd6, 0, 0, 0, 4'd14), 1, mk(0,0,0,0,0,0,0,0), 0, a);
    idle(4);
    check("R11", "refill after drain issues", icyc[14], a + 1);
  endtask

  initial begin
    clear_log();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_multi();
    t_raw_ooo();
    t_war_waw();
    t_reg0();
    t_cc();
    t_units();
    t_fence();
    t_stall_refill();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #4ms;
    total++;
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule